// File: doc/BRIEF.md
# PLL Configuration Sequencer

This block reprograms a PLL that is controlled by two 32-bit control registers. It does the job in hardware, without boot software. A requester presents the wanted pre-divider, multiplier and post-divider, the system clock frequency and the PLL output frequency, both in MHz, and pulses a start strobe. The sequencer first reads the two control registers. If the live configuration already equals the request and the PLL is running out of reset and out of bypass, it finishes at once and writes nothing.

Otherwise it carries out a fixed series of read-modify-write updates:

1. It asserts the PLL reset.
2. It loads the new divider, multiplier and bandwidth fields with bypass forced on.
3. It holds reset for a padded minimum time.
4. It releases reset and waits for the PLL to settle.
5. It drops bypass.

Both waits are counted in system clock cycles with one shared down-counter. In this block the two control registers are local. The PLL reads them through two output ports. A host port can write either register while the sequencer is idle.

Top module: `pcs_pll_seq`

## Requirements
- R1: While `rst_n` is low, both control registers clear to zero, and `busy_o` and `done_o` are low.
- R2: A `start_i` pulse taken while idle raises `busy_o` on the following cycle. `busy_o` stays high up to and including the single cycle in which `done_o` is high, and falls on the cycle after. A `start_i` that arrives while `busy_o` is high has no effect.
- R3: The sequence is skipped when all of these hold:
  - register A bit 23 (bypass) is 0;
  - register B bit 13 (reset) is 0;
  - A[5:0]+1 equals the pre-divider request;
  - A[18:6]+1 equals the multiplier request;
  - A[22:19]+1 equals the post-divider request;
  - the 12-bit value {B[3:0],A[31:24]}+1 equals the multiplier request shifted right by one.

  When skipped, `done_o` rises in the second cycle after the start edge (busy for 2 cycles) and neither register changes.
- R4: Each of the pre-divider, multiplier and post-divider is stored as (request − 1), or as 0 when the request is 0. The fields are A[5:0], A[18:6] and A[22:19].
- R5: The bandwidth value is ((multiplier >> 1) − 1) modulo 4096. Its low 8 bits go to A[31:24] and its high 4 bits to B[3:0].
- R6: On a reprogram, the edge after evaluation sets B[13]. The next edge writes all of register A with bypass A[23]=1. The next edge writes B[3:0]. Bypass is still 1 when the reset bit is cleared.
- R7: The reset-hold wait is D1 = 500 × sys_MHz. B[13] is cleared exactly D1+1 cycles after the edge that writes B[3:0].
- R8: The settle wait is D2 = sys_MHz × 100000 / pll_MHz, using integer division, with a PLL frequency of 0 treated as 1. A[23] is cleared exactly D2+1 cycles after the reset release. `done_o` is high in the cycle that follows, so a reprogram keeps `busy_o` high for D1+D2+6 cycles.
- R9: The sequencer never changes B bits other than B[3:0] and B[13].
- R10: With `host_we_i` high while idle, `host_wdata_i` is written to register A (`host_sel_i`=0) or register B (`host_sel_i`=1). The write is ignored while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Single-cycle request strobe |
| pre_div_i | input | 7 | Requested pre-divider |
| mult_i | input | 14 | Requested multiplier |
| post_div_i | input | 5 | Requested post-divider |
| sys_mhz_i | input | SYS_W (12) | System clock frequency in MHz |
| pll_mhz_i | input | PLL_W (12) | PLL output frequency in MHz |
| host_we_i | input | 1 | Host write strobe, honoured only while idle |
| host_sel_i | input | 1 | Host register select: 0 = A, 1 = B |
| host_wdata_i | input | 32 | Host write data |
| ctl_a_o | output | 32 | Control register A, as seen by the PLL |
| ctl_b_o | output | 32 | Control register B, as seen by the PLL |
| busy_o | output | 1 | High from the cycle after an accepted start until the end of the done cycle |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The reset-hold assertion compares the measured reset duration against the live `sys_mhz_i`, so it takes for granted that the request and frequency inputs stay constant while `busy_o` is high. The bypass-ordering and field-preservation checks assume that register changes during a busy period come only from the sequencer, not from a host write issued in the same cycle as start. The stimulus changes requests only while idle, and it issues host writes only in idle gaps or deliberately during a busy phase, where they must be dropped. It also re-pulses start mid-sequence with unchanged request values.

// File: rtl/pcs_pkg.sv
// Package: shared field layout, widths and state encoding for the PLL
// configuration sequencer. Bit positions are fixed by the PLL's decoding.
package pcs_pkg;
    localparam int REG_W      = 32;
    localparam int PRE_FW     = 6;
    localparam int MUL_FW     = 13;
    localparam int POST_FW    = 4;
    localparam int BW_W       = 12;
    localparam int BW_LO_W    = 8;
    localparam int BW_HI_W    = BW_W - BW_LO_W;
    localparam int PRE_LSB    = 0;
    localparam int MUL_LSB    = PRE_LSB + PRE_FW;
    localparam int POST_LSB   = MUL_LSB + MUL_FW;
    localparam int BYP_BIT    = POST_LSB + POST_FW;
    localparam int BWLO_LSB   = BYP_BIT + 1;
    localparam int BWHI_LSB   = 0;
    localparam int RST_BIT    = 13;

    typedef struct packed {
        logic [PRE_FW:0]  pre;
        logic [MUL_FW:0]  mul;
        logic [POST_FW:0] post;
    } pll_req_t;

    typedef enum logic [2:0] {
        S_IDLE, S_EVAL, S_WR_A, S_WR_B, S_HOLD, S_SETTLE, S_DONE
    } seq_state_t;
endpackage

// File: rtl/pcs_ctl_regs.sv
// Module: the two PLL control registers. The sequencer write port always
// wins; the host port is honoured only when host_en_i is high.
// Assumes the sequencer never writes a register in a cycle host_en_i is high.
module pcs_ctl_regs
    import pcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_en_i,
    input  logic             host_we_i,
    input  logic             host_sel_i,
    input  logic [REG_W-1:0] host_wdata_i,
    input  logic             seq_we_a_i,
    input  logic [REG_W-1:0] seq_a_i,
    input  logic             seq_we_b_i,
    input  logic [REG_W-1:0] seq_b_i,
    output logic [REG_W-1:0] reg_a_o,
    output logic [REG_W-1:0] reg_b_o
);
    // Register A update: sequencer first, then an enabled host write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          reg_a_o <= '0;
        else if (seq_we_a_i)                                 reg_a_o <= seq_a_i;
        else if (host_en_i && host_we_i && !host_sel_i)      reg_a_o <= host_wdata_i;
    end

    // Register B update: same priority as register A.
    always_ff @(posedge clk) begin
        if (!rst_n)                                          reg_b_o <= '0;
        else if (seq_we_b_i)                                 reg_b_o <= seq_b_i;
        else if (host_en_i && host_we_i && host_sel_i)       reg_b_o <= host_wdata_i;
    end
endmodule

// File: rtl/pcs_field_codec.sv
// Module: compares the live register contents with a request and forms
// the new register values. Purely combinational.
// Assumes request widths are one bit wider than the stored fields.
module pcs_field_codec
    import pcs_pkg::*;
(
    input  pll_req_t         req_i,
    input  logic [REG_W-1:0] reg_a_i,
    input  logic [REG_W-1:0] reg_b_i,
    output logic             match_o,
    output logic [REG_W-1:0] prog_a_o,
    output logic [REG_W-1:0] bw_b_o
);
    logic [PRE_FW-1:0]  pre_f;
    logic [MUL_FW-1:0]  mul_f;
    logic [POST_FW-1:0] post_f;
    logic [BW_W-1:0]    bw;
    logic [MUL_FW-1:0]  half_mul;

    // Encode requests as value minus one, with zero kept as zero.
    always_comb begin
        pre_f    = (req_i.pre  == '0) ? '0 : PRE_FW'(req_i.pre  - 1'b1);
        mul_f    = (req_i.mul  == '0) ? '0 : MUL_FW'(req_i.mul  - 1'b1);
        post_f   = (req_i.post == '0) ? '0 : POST_FW'(req_i.post - 1'b1);
        half_mul = req_i.mul[MUL_FW:1];
        bw       = BW_W'(half_mul - 1'b1);
    end

    // Decide whether the live registers already hold the request.
    always_comb begin
        match_o = !reg_a_i[BYP_BIT] && !reg_b_i[RST_BIT]
            && ({1'b0, reg_a_i[PRE_LSB +: PRE_FW]}   + 1'b1 == req_i.pre)
            && ({1'b0, reg_a_i[MUL_LSB +: MUL_FW]}   + 1'b1 == req_i.mul)
            && ({1'b0, reg_a_i[POST_LSB +: POST_FW]} + 1'b1 == req_i.post)
            && ({1'b0, reg_b_i[BWHI_LSB +: BW_HI_W], reg_a_i[BWLO_LSB +: BW_LO_W]} + 1'b1
                == half_mul);
    end

    // Build the new register A image (bypass on) and the new register B image.
    always_comb begin
        prog_a_o                         = reg_a_i;
        prog_a_o[PRE_LSB +: PRE_FW]      = pre_f;
        prog_a_o[MUL_LSB +: MUL_FW]      = mul_f;
        prog_a_o[POST_LSB +: POST_FW]    = post_f;
        prog_a_o[BYP_BIT]                = 1'b1;
        prog_a_o[BWLO_LSB +: BW_LO_W]    = bw[BW_LO_W-1:0];
        bw_b_o                           = reg_b_i;
        bw_b_o[BWHI_LSB +: BW_HI_W]      = bw[BW_W-1:BW_LO_W];
    end
endmodule

// File: rtl/pcs_delay_calc.sv
// Module: turns the frequencies into the two wait lengths in system cycles.
// Assumes CNT_W can hold SETTLE_OUT_CYC times the largest system frequency.
module pcs_delay_calc #(
    parameter int SYS_W          = 12,
    parameter int PLL_W          = 12,
    parameter int CNT_W          = 32,
    parameter int HOLD_FACTOR    = 500,
    parameter int SETTLE_OUT_CYC = 100000
) (
    input  logic [SYS_W-1:0] sys_mhz_i,
    input  logic [PLL_W-1:0] pll_mhz_i,
    output logic [CNT_W-1:0] hold_cyc_o,
    output logic [CNT_W-1:0] settle_cyc_o
);
    logic [CNT_W-1:0] divisor;

    // Hold = factor x sysMHz; settle = sysMHz x out-cycles / pllMHz (0 -> 1).
    always_comb begin
        divisor      = (pll_mhz_i == '0) ? CNT_W'(1) : CNT_W'(pll_mhz_i);
        hold_cyc_o   = CNT_W'(HOLD_FACTOR) * CNT_W'(sys_mhz_i);
        settle_cyc_o = (CNT_W'(sys_mhz_i) * CNT_W'(SETTLE_OUT_CYC)) / divisor;
    end
endmodule

// File: rtl/pcs_down_ctr.sv
// Module: loadable down-counter shared by both wait phases; stops at zero.
module pcs_down_ctr #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt;

    // Load has priority; decrement only while non-zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (load_i)              cnt <= load_val_i;
        else if (dec_i && cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero_o = (cnt == '0);
endmodule

// File: rtl/pcs_pll_seq.sv
// Module: top of the PLL configuration sequencer. It latches a request on
// start, skips when the PLL already matches, and otherwise runs the
// reset / program / hold / release / settle / unbypass series.
// Assumes inputs other than start_i and the host port stay stable while busy.
module pcs_pll_seq
    import pcs_pkg::*;
#(
    parameter int SYS_W          = 12,
    parameter int PLL_W          = 12,
    parameter int CNT_W          = 32,
    parameter int HOLD_FACTOR    = 500,
    parameter int SETTLE_OUT_CYC = 100000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [PRE_FW:0]    pre_div_i,
    input  logic [MUL_FW:0]    mult_i,
    input  logic [POST_FW:0]   post_div_i,
    input  logic [SYS_W-1:0]   sys_mhz_i,
    input  logic [PLL_W-1:0]   pll_mhz_i,
    input  logic               host_we_i,
    input  logic               host_sel_i,
    input  logic [REG_W-1:0]   host_wdata_i,
    output logic [REG_W-1:0]   ctl_a_o,
    output logic [REG_W-1:0]   ctl_b_o,
    output logic               busy_o,
    output logic               done_o
);
    seq_state_t       state, state_nx;
    pll_req_t         req_q;
    logic [SYS_W-1:0] sys_q;
    logic [PLL_W-1:0] pll_q;
    logic             match;
    logic [REG_W-1:0] prog_a, bw_b;
    logic [CNT_W-1:0] hold_cyc, settle_cyc, load_val;
    logic             ctr_load, ctr_dec, ctr_zero;
    logic             seq_we_a, seq_we_b;
    logic [REG_W-1:0] seq_a, seq_b;

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Capture the request when an idle start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= '0;
            sys_q <= '0;
            pll_q <= '0;
        end else if (state == S_IDLE && start_i) begin
            req_q <= '{pre: pre_div_i, mul: mult_i, post: post_div_i};
            sys_q <= sys_mhz_i;
            pll_q <= pll_mhz_i;
        end
    end

    pcs_field_codec u_codec (
        .req_i    (req_q),
        .reg_a_i  (ctl_a_o),
        .reg_b_i  (ctl_b_o),
        .match_o  (match),
        .prog_a_o (prog_a),
        .bw_b_o   (bw_b)
    );

    pcs_delay_calc #(
        .SYS_W(SYS_W), .PLL_W(PLL_W), .CNT_W(CNT_W),
        .HOLD_FACTOR(HOLD_FACTOR), .SETTLE_OUT_CYC(SETTLE_OUT_CYC)
    ) u_delay (
        .sys_mhz_i    (sys_q),
        .pll_mhz_i    (pll_q),
        .hold_cyc_o   (hold_cyc),
        .settle_cyc_o (settle_cyc)
    );

    pcs_down_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ctr_load),
        .load_val_i (load_val),
        .dec_i      (ctr_dec),
        .zero_o     (ctr_zero)
    );

    pcs_ctl_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_en_i    (state == S_IDLE),
        .host_we_i    (host_we_i),
        .host_sel_i   (host_sel_i),
        .host_wdata_i (host_wdata_i),
        .seq_we_a_i   (seq_we_a),
        .seq_a_i      (seq_a),
        .seq_we_b_i   (seq_we_b),
        .seq_b_i      (seq_b),
        .reg_a_o      (ctl_a_o),
        .reg_b_o      (ctl_b_o)
    );

    // Next state, register write requests and counter control.
    always_comb begin
        state_nx = state;
        seq_we_a = 1'b0;
        seq_we_b = 1'b0;
        seq_a    = ctl_a_o;
        seq_b    = ctl_b_o;
        ctr_load = 1'b0;
        ctr_dec  = 1'b0;
        load_val = hold_cyc;
        case (state)
            S_IDLE:   if (start_i) state_nx = S_EVAL;
            S_EVAL: begin
                if (match) begin
                    state_nx = S_DONE;
                end else begin
                    seq_we_b         = 1'b1;
                    seq_b[RST_BIT]   = 1'b1;
                    state_nx         = S_WR_A;
                end
            end
            S_WR_A: begin
                seq_we_a = 1'b1;
                seq_a    = prog_a;
                state_nx = S_WR_B;
            end
            S_WR_B: begin
                seq_we_b = 1'b1;
                seq_b    = bw_b;
                ctr_load = 1'b1;
                load_val = hold_cyc;
                state_nx = S_HOLD;
            end
            S_HOLD: begin
                if (ctr_zero) begin
                    seq_we_b       = 1'b1;
                    seq_b[RST_BIT] = 1'b0;
                    ctr_load       = 1'b1;
                    load_val       = settle_cyc;
                    state_nx       = S_SETTLE;
                end else begin
                    ctr_dec = 1'b1;
                end
            end
            S_SETTLE: begin
                if (ctr_zero) begin
                    seq_we_a       = 1'b1;
                    seq_a[BYP_BIT] = 1'b0;
                    state_nx       = S_DONE;
                end else begin
                    ctr_dec = 1'b1;
                end
            end
            S_DONE:   state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    assign busy_o = (state != S_IDLE);
    assign done_o = (state == S_DONE);
endmodule

// File: rtl/pcs_pll_seq_chk.sv
// Module: property checker bound to the sequencer top. It measures the
// reset-hold length with its own counter rather than a long $past window.
// Assumes sys_mhz_i is stable while busy_o is high.
module pcs_pll_seq_chk #(
    parameter int SYS_W       = 12,
    parameter int CNT_W       = 32,
    parameter int HOLD_FACTOR = 500
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy_o,
    input logic             done_o,
    input logic [31:0]      ctl_a_o,
    input logic [31:0]      ctl_b_o,
    input logic [SYS_W-1:0] sys_mhz_i
);
    localparam logic [31:0] B_SEQ_BITS = 32'h0000_200F;
    logic [CNT_W-1:0] rst_run;

    // Count consecutive cycles with the PLL reset bit set.
    always_ff @(posedge clk) begin
        if (!rst_n)          rst_run <= '0;
        else if (ctl_b_o[13]) rst_run <= rst_run + 1'b1;
        else                 rst_run <= '0;
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R2
    AST_DONE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o); // R2
    AST_IDLE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !busy_o); // R2
    AST_B_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> ((ctl_b_o & ~B_SEQ_BITS) == ($past(ctl_b_o) & ~B_SEQ_BITS))); // R9
    AST_BYPASS_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ctl_b_o[13]) && busy_o) |-> ctl_a_o[23]); // R6
    AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ctl_b_o[13]) && busy_o)
        |-> (rst_run >= CNT_W'(HOLD_FACTOR) * CNT_W'(sys_mhz_i))); // R7
    AST_UNBYPASS_OUT_OF_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ctl_a_o[23]) && busy_o) |-> !ctl_b_o[13]); // R8
endmodule

bind pcs_pll_seq pcs_pll_seq_chk #(
    .SYS_W(SYS_W), .CNT_W(CNT_W), .HOLD_FACTOR(HOLD_FACTOR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .ctl_a_o   (ctl_a_o),
    .ctl_b_o   (ctl_b_o),
    .sys_mhz_i (sys_mhz_i)
);

// File: tb/sim_pcs_pll_seq.sv
// Bench: behavioural cycle model of the sequencer, compared every cycle.
module sim_pcs_pll_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  pre = '0;
    logic [13:0] mul = '0;
    logic [4:0]  post = '0;
    logic [11:0] sys = '0;
    logic [11:0] pll = '0;
    logic        hwe = 1'b0;
    logic        hsel = 1'b0;
    logic [31:0] hdata = '0;
    logic [31:0] ctl_a, ctl_b;
    logic        busy, done;

    int    compared = 0;
    int    mismatched = 0;
    bit    cmp_en = 1'b0;
    int    busy_cnt = 0;
    string cur_tag = "R1";
    logic [31:0] m_a = '0, m_b = '0;
    logic        m_busy = 1'b0, m_done = 1'b0;

    pcs_pll_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start),
        .pre_div_i(pre), .mult_i(mul), .post_div_i(post),
        .sys_mhz_i(sys), .pll_mhz_i(pll),
        .host_we_i(hwe), .host_sel_i(hsel), .host_wdata_i(hdata),
        .ctl_a_o(ctl_a), .ctl_b_o(ctl_b), .busy_o(busy), .done_o(done)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(ctl_a === m_a, {cur_tag, " ctl_a"}, ctl_a, m_a);
            chk(ctl_b === m_b, {cur_tag, " ctl_b"}, ctl_b, m_b);
            chk(busy === m_busy, "R2 busy", 32'(busy), 32'(m_busy));
            chk(done === m_done, "R2 done", 32'(done), 32'(m_done));
            if (busy) busy_cnt++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic host_write(input bit sel, input logic [31:0] data);
        hwe = 1'b1; hsel = sel; hdata = data;
        step();
        hwe = 1'b0;
        if (!m_busy) begin
            if (sel) m_b = data; else m_a = data;
        end
    endtask

    function automatic int enc(input int v);
        return (v == 0) ? 0 : v - 1;
    endfunction

    // Run one request; poke = re-start and host-write during the sequence.
    task automatic run_seq(input int p, input int m, input int q, input int s,
                           input int f, input bit poke);
        int  bw, d1, d2, exp_len;
        bit  skip;
        logic [31:0] exp_a;
        bw   = ((m >> 1) - 1) & 12'hFFF;
        d1   = 500 * s;
        d2   = (s * 100000) / ((f == 0) ? 1 : f);
        exp_a = (32'(bw & 8'hFF) << 24) | (32'd1 << 23) | (32'(enc(q)) << 19)
              | (32'(enc(m)) << 6) | 32'(enc(p));
        skip = (m_a[23] == 1'b0) && (m_b[13] == 1'b0)
            && (int'(m_a[5:0]) + 1 == p) && (int'(m_a[18:6]) + 1 == m)
            && (int'(m_a[22:19]) + 1 == q)
            && ((int'(m_b[3:0]) * 256 + int'(m_a[31:24]) + 1) == (m >> 1));
        pre = 7'(p); mul = 14'(m); post = 5'(q); sys = 12'(s); pll = 12'(f);
        busy_cnt = 0;
        start = 1'b1;
        step();
        start = 1'b0;
        m_busy = 1'b1;
        if (skip) begin
            cur_tag = "R3";
            step();
            m_done = 1'b1;
            step();
            m_done = 1'b0; m_busy = 1'b0;
            step();
            chk(busy_cnt == 2, "R3 skip busy length", 32'(busy_cnt), 32'd2);
        end else begin
            cur_tag = "R6";
            step();
            m_b[13] = 1'b1;
            if (poke) begin
                start = 1'b1; hwe = 1'b1; hsel = 1'b0; hdata = 32'h0;
            end
            step();
            start = 1'b0; hwe = 1'b0;
            m_a = exp_a;
            step();
            m_b[3:0] = 4'(bw >> 8);
            cur_tag = "R7";
            repeat (d1) step();
            step();
            m_b[13] = 1'b0;
            cur_tag = "R8";
            repeat (d2) step();
            step();
            m_a[23] = 1'b0;
            m_done = 1'b1;
            step();
            m_done = 1'b0; m_busy = 1'b0;
            step();
            exp_len = d1 + d2 + 6;
            chk(busy_cnt == exp_len, "R8 reprogram busy length",
                32'(busy_cnt), 32'(exp_len));
            chk(ctl_a === (exp_a & ~32'h0080_0000), "R4 R5 final register A",
                ctl_a, exp_a & ~32'h0080_0000);
            chk(ctl_b[3:0] === 4'(bw >> 8), "R5 bandwidth high bits",
                32'(ctl_b[3:0]), 32'(bw >> 8));
        end
    endtask

    initial begin
        repeat (3) step();
        chk(ctl_a === 32'h0 && ctl_b === 32'h0, "R1 registers in reset", ctl_a, 32'h0);
        chk(busy === 1'b0 && done === 1'b0, "R1 handshake in reset",
            32'({busy, done}), 32'h0);
        rst_n = 1'b1;
        step();
        cmp_en = 1'b1;
        // R10: host preload while idle, B carries foreign bits to preserve (R9).
        cur_tag = "R10";
        host_write(1'b1, 32'hFFFF_C0F0);
        host_write(1'b0, 32'h1234_5678);
        // Full reprogram with mid-sequence start and host write (R2, R10).
        run_seq(2, 40, 2, 2, 1000, 1'b1);
        chk(ctl_b[31:14] === 18'h3FFFF && ctl_b[12:4] === 9'h00F,
            "R9 foreign bits of B kept", ctl_b, 32'hFFFF_C0F0);
        // Same request again: skip path (R3).
        run_seq(2, 40, 2, 2, 1000, 1'b0);
        // Reset bit set by host breaks the match (R3) and forces a reprogram.
        cur_tag = "R10";
        host_write(1'b1, ctl_b | 32'h0000_2000);
        run_seq(2, 40, 2, 1, 500, 1'b0);
        // Unit multiplier: bandwidth wraps to all ones (R5).
        run_seq(1, 1, 1, 1, 1000, 1'b0);
        // Zero dividers and zero PLL frequency treated as one (R4, R8).
        run_seq(0, 6, 0, 1, 0, 1'b0);
        chk(ctl_a[5:0] === 6'd0 && ctl_a[22:19] === 4'd0, "R4 zero request fields",
            ctl_a, 32'h0);
        cmp_en = 1'b0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule